// File: doc/BRIEF.md
# Piecewise-Linear Activation Interpolator

This block evaluates a neuron activation curve by straight-line interpolation between stored points. Each 18-bit input word is split in two. The upper nine bits pick one of 512 segments. The lower nine bits give the position inside that segment. Two tables are indexed by the segment number: one stores the segment's starting value and the other stores its slope. The result is the starting value plus the slope scaled by the position. It is clamped to the unsigned 16-bit range.

The datapath has four register stages: input capture, table read, multiply, and add with clamp. A new word can enter on every clock. Each accepted word produces exactly one output pulse four cycles later. The curve depends only on the table contents, so the same logic can serve different layers. For example, a binary output layer can load a two-level step (zero slope everywhere), while hidden layers load a smooth curve. The tables are loaded through a separate write port, one entry per cycle, and can be rewritten at any time.

Top module: `pwl_act_interp`

## Requirements
- R1: While reset is high, and on the first cycle after it, `out_valid` is 0 and `out_value` is 0.
- R2: Bits 17..9 of `in_word` select the table entry (0 to 511). Bits 8..0 are the unsigned offset inside the segment.
- R3: Each result equals base + floor(slope × offset / 512). Here base is the unsigned 16-bit entry and slope is the two's-complement 16-bit entry. A negative term rounds toward minus infinity.
- R4: Every cycle with `in_valid` high produces exactly one `out_valid` pulse, exactly 4 clock cycles later. This holds for back-to-back inputs. No pulse appears without a matching input.
- R5: While `out_valid` is low, `out_value` keeps the last result delivered.
- R6: A sum below 0 is output as 0. A sum above 65535 is output as 65535.
- R7: When `tbl_we` is high, `tbl_data` is written at `tbl_addr`. The target is the base table when `tbl_sel` is 0 and the slope table when `tbl_sel` is 1. The other table is left unchanged.
- R8: A table write is seen by inputs accepted in the same cycle as the write or later. An input accepted in any earlier cycle uses the old entry.
- R9: With zero slope in every entry, base 0 below entry 256 and 65535 from entry 256 upward, the output is a two-level step that ignores the offset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks `in_word` as a value to evaluate |
| in_word | input | 18 | Segment index (upper 9 bits) and offset (lower 9 bits) |
| tbl_we | input | 1 | Table write strobe |
| tbl_sel | input | 1 | 0 writes the base table, 1 writes the slope table |
| tbl_addr | input | 9 | Table entry to write |
| tbl_data | input | 16 | Value to write; read as signed in the slope table |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| out_value | output | 16 | Interpolated, clamped result |

## Verification
A smooth table mixes positive and negative slopes. It is driven with single words and with a back-to-back burst of varied indices and offsets. This separates a correct index/offset split from a swapped one and confirms the valid pipeline neither drops nor duplicates pulses. Extreme entries push the sum past both ends of the range and use a small negative slope with offset 1. These checks tell clamping from wrap-around and floor rounding from truncation. Writes to one entry are interleaved with reads of that entry one cycle before, during and after the write, to pin down when an update takes effect and which table `tbl_sel` reaches. A two-level step table confirms that a zero slope makes the offset irrelevant.

// File: rtl/pwl_pkg.sv
`timescale 1ns/1ps
package pwl_pkg;
  // Which coefficient table a write lands in.
  typedef enum logic {
    TBL_BASE  = 1'b0,
    TBL_SLOPE = 1'b1
  } tbl_sel_e;

  localparam int NUM_TBL = 2;
endpackage

// File: rtl/pwl_coef_ram.sv
`timescale 1ns/1ps
// Simple dual-port coefficient store, registered read, read-before-write.
module pwl_coef_ram #(
  parameter int AW = 9,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/pwl_slope_mul.sv
`timescale 1ns/1ps
// Stage 3: signed slope times unsigned offset; base carried alongside.
module pwl_slope_mul #(
  parameter int VW = 16,
  parameter int OW = 9
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_v,
  input  logic [VW-1:0]      base,
  input  logic [VW-1:0]      slope,
  input  logic [OW-1:0]      off,
  output logic               out_v,
  output logic [VW-1:0]      base_q,
  output logic [VW+OW:0]     prod
);
  localparam int PW = VW + OW + 1;

  logic signed [PW-1:0] prod_c;

  always_comb begin
    prod_c = $signed(slope) * $signed({1'b0, off});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_v <= 1'b0;
    end else begin
      out_v <= in_v;
    end
    base_q <= base;
    prod   <= prod_c;
  end
endmodule

// File: rtl/pwl_sat_add.sv
`timescale 1ns/1ps
// Stage 4: base + (product >> OW, floor), clamped to [0, 2^VW-1].
module pwl_sat_add #(
  parameter int VW = 16,
  parameter int OW = 9
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_v,
  input  logic [VW-1:0]  base,
  input  logic [VW+OW:0] prod,
  output logic           out_v,
  output logic [VW-1:0]  out_val
);
  localparam int PW = VW + OW + 1;
  localparam logic signed [PW-1:0] MAXV = {{(PW-VW){1'b0}}, {VW{1'b1}}};

  logic signed [PW-1:0] term;
  logic signed [PW-1:0] sum;
  logic [VW-1:0]        clamped;

  always_comb begin
    term = $signed(prod) >>> OW;
    sum  = $signed({{(PW-VW){1'b0}}, base}) + term;
    if (sum < 0) begin
      clamped = '0;
    end else if (sum > MAXV) begin
      clamped = {VW{1'b1}};
    end else begin
      clamped = sum[VW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_v   <= 1'b0;
      out_val <= '0;
    end else begin
      out_v <= in_v;
      if (in_v) begin
        out_val <= clamped;
      end
    end
  end
endmodule

// File: rtl/pwl_act_interp.sv
`timescale 1ns/1ps
// Four-stage piecewise-linear activation unit.
// Stage 1 capture, stage 2 table read, stage 3 multiply, stage 4 add/clamp.
module pwl_act_interp #(
  parameter int IN_W  = 18,
  parameter int IDX_W = 9,
  parameter int VAL_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [IN_W-1:0]    in_word,
  input  logic               tbl_we,
  input  logic               tbl_sel,
  input  logic [IDX_W-1:0]   tbl_addr,
  input  logic [VAL_W-1:0]   tbl_data,
  output logic               out_valid,
  output logic [VAL_W-1:0]   out_value
);
  import pwl_pkg::*;

  localparam int OFF_W = IN_W - IDX_W;
  localparam int PW    = VAL_W + OFF_W + 1;

  // Stage 1: input capture
  logic              s1_v;
  logic [IDX_W-1:0]  s1_idx;
  logic [OFF_W-1:0]  s1_off;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v <= 1'b0;
    end else begin
      s1_v <= in_valid;
    end
    s1_idx <= in_word[IN_W-1:OFF_W];
    s1_off <= in_word[OFF_W-1:0];
  end

  // Stage 2: both tables read in parallel
  logic [VAL_W-1:0] tbl_rd [NUM_TBL];

  for (genvar t = 0; t < NUM_TBL; t++) begin : g_tbl
    pwl_coef_ram #(
      .AW (IDX_W),
      .DW (VAL_W)
    ) ram_i (
      .clk   (clk),
      .we    (tbl_we && (tbl_sel == 1'(t))),
      .waddr (tbl_addr),
      .wdata (tbl_data),
      .raddr (s1_idx),
      .rdata (tbl_rd[t])
    );
  end

  logic             s2_v;
  logic [OFF_W-1:0] s2_off;

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_v <= 1'b0;
    end else begin
      s2_v <= s1_v;
    end
    s2_off <= s1_off;
  end

  // Stage 3: multiply
  logic             mul_v;
  logic [VAL_W-1:0] mul_base;
  logic [PW-1:0]    mul_prod;

  pwl_slope_mul #(
    .VW (VAL_W),
    .OW (OFF_W)
  ) mul_i (
    .clk    (clk),
    .rst    (rst),
    .in_v   (s2_v),
    .base   (tbl_rd[int'(TBL_BASE)]),
    .slope  (tbl_rd[int'(TBL_SLOPE)]),
    .off    (s2_off),
    .out_v  (mul_v),
    .base_q (mul_base),
    .prod   (mul_prod)
  );

  // Stage 4: add and clamp, registered output
  pwl_sat_add #(
    .VW (VAL_W),
    .OW (OFF_W)
  ) add_i (
    .clk     (clk),
    .rst     (rst),
    .in_v    (mul_v),
    .base    (mul_base),
    .prod    (mul_prod),
    .out_v   (out_valid),
    .out_val (out_value)
  );
endmodule

// File: rtl/pwl_act_interp_chk.sv
`timescale 1ns/1ps
module pwl_act_interp_chk #(
  parameter int VAL_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             out_valid,
  input logic [VAL_W-1:0] out_value,
  input logic [VAL_W-1:0] mul_base,
  input logic             prod_neg
);
  // Cycles since reset was released, saturating.
  logic [2:0] since_rst;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_rst <= '0;
    end else if (since_rst != 3'd7) begin
      since_rst <= since_rst + 3'd1;
    end
  end

  // R1
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!out_valid && out_value == '0));

  // R4
  p_latency_r4: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 3'd4) |-> (out_valid == $past(in_valid, 4)));

  // R5
  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 3'd1 && !out_valid) |-> $stable(out_value));

  // R3: non-negative slope term never drops below the base
  p_pos_term_r3: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 3'd4 && out_valid && !$past(prod_neg)) |->
      (out_value >= $past(mul_base)));

  // R3: negative slope term never rises above the base
  p_neg_term_r3: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 3'd4 && out_valid && $past(prod_neg)) |->
      (out_value <= $past(mul_base)));
endmodule

bind pwl_act_interp pwl_act_interp_chk #(
  .VAL_W (VAL_W)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .out_value (out_value),
  .mul_base  (mul_base),
  .prod_neg  (mul_prod[PW-1])
);

// File: tb/pwl_act_interp_tb_top.sv
`timescale 1ns/1ps
module pwl_act_interp_tb_top;
  localparam int N = 512;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [17:0] in_word;
  logic        tbl_we;
  logic        tbl_sel;
  logic [8:0]  tbl_addr;
  logic [15:0] tbl_data;
  logic        out_valid;
  logic [15:0] out_value;

  always #10 clk = ~clk;

  pwl_act_interp dut_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_word   (in_word),
    .tbl_we    (tbl_we),
    .tbl_sel   (tbl_sel),
    .tbl_addr  (tbl_addr),
    .tbl_data  (tbl_data),
    .out_valid (out_valid),
    .out_value (out_value)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int    sh_base [N];
  int    sh_slope[N];
  int    q_val[$];
  int    q_cyc[$];
  string q_tag[$];
  int    total = 0;
  int    bad = 0;
  int    last_out = 0;
  bit    mon_on = 1'b0;
  bit    done = 1'b0;
  int    m_val, m_cyc;
  string m_tag;

  function automatic int model(int b, int g, int off);
    int p, s;
    p = g * off;
    s = b + (p >>> 9);
    if (s < 0) return 0;
    if (s > 65535) return 65535;
    return s;
  endfunction

  task automatic chk(string req, int act, int exp, string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // One cycle of stimulus; the scoreboard entry is computed after any write
  // in the same cycle (R8: same-cycle writes are visible).
  task automatic step(bit v, int idx, int off, bit we, bit sel, int addr,
                      int data, string tag);
    @(negedge clk);
    in_valid = v;
    in_word  = {idx[8:0], off[8:0]};
    tbl_we   = we;
    tbl_sel  = sel;
    tbl_addr = addr[8:0];
    tbl_data = data[15:0];
    if (we) begin
      if (sel) sh_slope[addr] = data;
      else     sh_base[addr]  = data;
    end
    if (v) begin
      q_val.push_back(model(sh_base[idx], sh_slope[idx], off));
      q_cyc.push_back(cyc);
      q_tag.push_back(tag);
    end
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, "");
  endtask

  task automatic go(int idx, int off, string tag);
    step(1, idx, off, 0, 0, 0, 0, tag);
  endtask

  task automatic wr(bit sel, int addr, int data);
    step(0, 0, 0, 1, sel, addr, data, "");
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (mon_on) begin
      if (out_valid) begin
        if (q_val.size() == 0) begin
          total++;
          bad++;
          $display("FAIL R4 unexpected pulse: actual=%0d expected=none", out_value);
        end else begin
          m_val = q_val.pop_front();
          m_cyc = q_cyc.pop_front();
          m_tag = q_tag.pop_front();
          chk(m_tag, int'(out_value), m_val, "value");
          chk("R4", cyc - m_cyc, 4, "latency");
          last_out = int'(out_value);
        end
      end else begin
        chk("R5", int'(out_value), last_out, "hold between results");
      end
    end
  end

  initial begin
    rst = 1'b1;
    in_valid = 1'b0; in_word = '0;
    tbl_we = 1'b0; tbl_sel = 1'b0; tbl_addr = '0; tbl_data = '0;
    repeat (3) @(negedge clk);
    chk("R1", int'(out_valid), 0, "valid in reset");
    chk("R1", int'(out_value), 0, "value in reset");
    rst = 1'b0;
    @(negedge clk);
    chk("R1", int'(out_valid), 0, "valid after reset");
    chk("R1", int'(out_value), 0, "value after reset");
    mon_on = 1'b1;

    // Smooth curve with mixed-sign slopes (R7 table loading)
    for (int i = 0; i < N; i++) begin
      wr(0, i, i * 128);
      wr(1, i, ((i % 7) * 37) - 100);
    end
    idle();

    // R2: index and offset split
    go(3, 0, "R2");
    idle();
    go(0, 3, "R2");
    idle(); idle();
    go(300, 256, "R2");
    go(511, 1, "R3");
    go(6, 511, "R3");
    repeat (5) idle();

    // R3/R4: back-to-back burst of varied words
    for (int i = 0; i < 20; i++) go((i * 29 + 5) % N, (i * 53 + 7) % N, "R3");
    repeat (6) idle();

    // R6: clamp high and low; R3: floor for small negative term
    wr(0, 511, 65500); wr(1, 511, 32767);
    wr(0, 0, 10);      wr(1, 0, -32768);
    wr(0, 1, 100);     wr(1, 1, -3);
    go(511, 511, "R6");
    go(0, 511, "R6");
    go(1, 1, "R3");
    go(1, 0, "R3");
    repeat (6) idle();

    // R7: each select reaches only its own table
    wr(0, 40, 7777);
    go(40, 0, "R7");
    wr(1, 40, 1024);
    go(40, 256, "R7");
    go(40, 0, "R7");
    repeat (6) idle();

    // R8: reads one cycle before, during and after a write
    go(20, 10, "R8");
    step(1, 20, 10, 1, 0, 20, 5000, "R8");
    go(20, 10, "R8");
    step(1, 20, 100, 1, 1, 20, -512, "R8");
    go(20, 100, "R8");
    repeat (6) idle();

    // R9: two-level step curve
    for (int i = 0; i < N; i++) begin
      wr(0, i, (i < 256) ? 0 : 65535);
      wr(1, i, 0);
    end
    go(100, 300, "R9");
    go(255, 511, "R9");
    go(256, 0, "R9");
    go(400, 77, "R9");
    repeat (8) idle();

    chk("R4", q_val.size(), 0, "outstanding results");
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule